// File: doc/BRIEF.md
# PCM Timeslot Drop/Insert Marker

This block sits beside a T1/E1 serial PCM port on a backplane that several line cards share. It follows the receive and transmit bit streams through their frames. It raises a per-slot strobe so that outside multiplexers can pick individual timeslots off the bus, or place them onto it. On the receive side, a drop strobe covers every bit of each slot whose receive table entry is set. On the transmit side, an insert strobe covers every bit of each slot whose transmit table entry is set. During those slots the serial output carries the alternate input in place of the normal transmit source. The output is always driven, and no slot is added or removed.

Each direction has its own bit clock, frame sync and one-bit-per-slot enable table. Software loads a table through a small write port that runs on that direction's clock. A write becomes visible only at the next frame start, so a frame in progress is never split between old and new settings. Input bits and syncs are sampled on the falling clock edge, and every output changes on the rising edge.

Top module: `pcm_slot_marker`

## Requirements
- R1: After reset, and until the first sync pulse is sampled in a direction, rx_drop and tx_insert stay low and tx_ser repeats tx_src. An asynchronous reset forces both strobes low at once.
- R2: The bit sampled while the sync input is high is frame position 0. A sync arriving in mid-frame realigns the count at once.
- R3: With e1_mode=1 a frame has 256 positions. Slot n covers positions 8n to 8n+7, and rx_drop is high for all eight bits of every slot whose receive entry is 1.
- R4: With e1_mode=0 a frame has 193 positions. Position 0 is the framing bit, and slot n (0 to 23) covers positions 8n+1 to 8n+8.
- R5: During the T1 framing bit both strobes are low, whatever the tables hold.
- R6: tx_insert is high for all bits of every transmit slot whose transmit entry is 1, and low otherwise.
- R7: tx_ser carries alt_dat during bits with tx_insert high, and carries tx_src during all other bits.
- R8: A table write (address = slot index, data 1 = enabled) changes no strobe in the current frame. It takes effect from the next frame start, whether that start comes from a sync or from a wrap.
- R9: The receive and transmit directions keep separate positions. A sync on one side does not move the other.
- R10: Inputs are sampled on the falling clock edge. rx_drop, tx_insert and tx_ser change only on the rising edge that follows.
- R11: Without further syncs, the position wraps from the last position of the frame back to 0 and keeps marking slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset |
| e1_mode | input | 1 | 1 selects the 32-slot frame, 0 selects the 24-slot frame with a framing bit |
| rx_clk | input | 1 | Receive bit clock |
| rx_sync | input | 1 | Receive frame sync; high during frame position 0 |
| rx_wr_en | input | 1 | Write strobe for the receive table |
| rx_wr_addr | input | 5 | Receive table slot index |
| rx_wr_data | input | 1 | Receive drop enable for the addressed slot |
| rx_drop | output | 1 | High for every bit of a receive slot that is dropped |
| tx_clk | input | 1 | Transmit bit clock |
| tx_sync | input | 1 | Transmit frame sync; high during frame position 0 |
| tx_src | input | 1 | Normal transmit serial data |
| alt_dat | input | 1 | Alternate serial data for inserted slots |
| tx_wr_en | input | 1 | Write strobe for the transmit table |
| tx_wr_addr | input | 5 | Transmit table slot index |
| tx_wr_data | input | 1 | Transmit insert enable for the addressed slot |
| tx_ser | output | 1 | Transmit serial data out, always driven |
| tx_insert | output | 1 | High for every bit of a transmit slot that is inserted |

## Verification
Some properties are checked on every cycle. The strobes stay quiet until a sync has been seen, and the framing bit that follows a T1 sync never carries a strobe. The serial output always equals whichever input the insert strobe selects for that bit. Other behaviour can only be shown by the bench's scenarios, because each case needs a known table and a known frame position:

- slot boundaries in both framings;
- the deferred table switch at the next frame;
- wrapping without a sync;
- an offset between the receive and transmit syncs;
- realignment by a mid-frame sync;
- outputs that hold still across the sampling edge.

// File: rtl/pcm_slot_marker.sv
module pcm_slot_marker #(
  parameter int SLOT_BITS = 8,
  parameter int E1_SLOTS  = 32,
  parameter int T1_SLOTS  = 24,
  localparam int ADDR_W   = $clog2(E1_SLOTS)
) (
  input  logic              rst_n,
  input  logic              e1_mode,
  input  logic              rx_clk,
  input  logic              rx_sync,
  input  logic              rx_wr_en,
  input  logic [ADDR_W-1:0] rx_wr_addr,
  input  logic              rx_wr_data,
  output logic              rx_drop,
  input  logic              tx_clk,
  input  logic              tx_sync,
  input  logic              tx_src,
  input  logic              alt_dat,
  input  logic              tx_wr_en,
  input  logic [ADDR_W-1:0] tx_wr_addr,
  input  logic              tx_wr_data,
  output logic              tx_ser,
  output logic              tx_insert
);
  localparam int E1_LEN  = E1_SLOTS * SLOT_BITS;
  localparam int T1_LEN  = T1_SLOTS * SLOT_BITS + 1;
  localparam int MAX_LEN = (E1_LEN > T1_LEN) ? E1_LEN : T1_LEN;
  localparam int POS_W   = $clog2(MAX_LEN);

  wire [POS_W-1:0] last_pos = e1_mode ? POS_W'(E1_LEN - 1) : POS_W'(T1_LEN - 1);

  // receive direction
  logic [POS_W-1:0]    rx_pos, rx_nxt, rx_spos;
  logic [ADDR_W-1:0]   rx_slot;
  logic                rx_seen, rx_fbit;
  logic [E1_SLOTS-1:0] rx_pend, rx_act;

  assign rx_nxt  = (rx_sync || rx_pos >= last_pos) ? '0 : rx_pos + 1'b1;
  assign rx_fbit = !e1_mode && (rx_pos == '0);
  assign rx_spos = e1_mode ? rx_pos : rx_pos - 1'b1;
  assign rx_slot = ADDR_W'(rx_spos / POS_W'(SLOT_BITS));

  always_ff @(negedge rx_clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_pos  <= '0;
      rx_seen <= 1'b0;
      rx_act  <= '0;
    end else begin
      rx_pos <= rx_nxt;
      if (rx_sync) rx_seen <= 1'b1;
      if (rx_nxt == '0) rx_act <= rx_pend;
    end
  end

  always_ff @(posedge rx_clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_pend <= '0;
      rx_drop <= 1'b0;
    end else begin
      if (rx_wr_en) rx_pend[rx_wr_addr] <= rx_wr_data;
      rx_drop <= rx_seen && !rx_fbit && rx_act[rx_slot];
    end
  end

  // transmit direction
  logic [POS_W-1:0]    tx_pos, tx_nxt, tx_spos;
  logic [ADDR_W-1:0]   tx_slot;
  logic                tx_seen, tx_fbit, tx_mark, src_q, alt_q;
  logic [E1_SLOTS-1:0] tx_pend, tx_act;

  assign tx_nxt  = (tx_sync || tx_pos >= last_pos) ? '0 : tx_pos + 1'b1;
  assign tx_fbit = !e1_mode && (tx_pos == '0);
  assign tx_spos = e1_mode ? tx_pos : tx_pos - 1'b1;
  assign tx_slot = ADDR_W'(tx_spos / POS_W'(SLOT_BITS));
  assign tx_mark = tx_seen && !tx_fbit && tx_act[tx_slot];

  always_ff @(negedge tx_clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_pos  <= '0;
      tx_seen <= 1'b0;
      tx_act  <= '0;
      src_q   <= 1'b0;
      alt_q   <= 1'b0;
    end else begin
      tx_pos <= tx_nxt;
      src_q  <= tx_src;
      alt_q  <= alt_dat;
      if (tx_sync) tx_seen <= 1'b1;
      if (tx_nxt == '0) tx_act <= tx_pend;
    end
  end

  always_ff @(posedge tx_clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_pend   <= '0;
      tx_insert <= 1'b0;
      tx_ser    <= 1'b0;
    end else begin
      if (tx_wr_en) tx_pend[tx_wr_addr] <= tx_wr_data;
      tx_insert <= tx_mark;
      tx_ser    <= tx_mark ? alt_q : src_q;
    end
  end
endmodule

// File: rtl/pcm_slot_marker_chk.sv
module pcm_slot_marker_chk (
  input logic rst_n,
  input logic e1_mode,
  input logic rx_clk,
  input logic rx_sync,
  input logic rx_drop,
  input logic tx_clk,
  input logic tx_sync,
  input logic tx_src,
  input logic alt_dat,
  input logic tx_ser,
  input logic tx_insert
);
  logic rx_got, tx_got, src_s, alt_s;

  always_ff @(negedge rx_clk or negedge rst_n) begin
    if (!rst_n) rx_got <= 1'b0;
    else if (rx_sync) rx_got <= 1'b1;
  end

  always_ff @(negedge tx_clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_got <= 1'b0;
      src_s  <= 1'b0;
      alt_s  <= 1'b0;
    end else begin
      if (tx_sync) tx_got <= 1'b1;
      src_s <= tx_src;
      alt_s <= alt_dat;
    end
  end

  // R1
  quiet_rx_chk: assert property (@(posedge rx_clk) disable iff (!rst_n) !rx_got |-> !rx_drop);
  // R1
  quiet_tx_chk: assert property (@(posedge tx_clk) disable iff (!rst_n) !tx_got |-> !tx_insert);
  // R7
  pass_src_chk: assert property (@(negedge tx_clk) disable iff (!rst_n) !tx_insert |-> tx_ser == src_s);
  // R7
  pass_alt_chk: assert property (@(negedge tx_clk) disable iff (!rst_n) tx_insert |-> tx_ser == alt_s);
  // R5
  fbit_rx_chk: assert property (@(negedge rx_clk) disable iff (!rst_n) (rx_sync && !e1_mode) |=> !rx_drop);
  // R5
  fbit_tx_chk: assert property (@(negedge tx_clk) disable iff (!rst_n) (tx_sync && !e1_mode) |=> !tx_insert);
endmodule

bind pcm_slot_marker pcm_slot_marker_chk chk_i (.*);

// File: tb/pcm_slot_marker_test.sv
module pcm_slot_marker_test;
  localparam int PERIOD = 10;

  logic rst_n = 1'b0, e1_mode = 1'b1;
  logic rx_clk = 1'b0, tx_clk = 1'b0;
  logic rx_sync = 1'b0, tx_sync = 1'b0, tx_src = 1'b0, alt_dat = 1'b0;
  logic rx_wr_en = 1'b0, tx_wr_en = 1'b0, rx_wr_data = 1'b0, tx_wr_data = 1'b0;
  logic [4:0] rx_wr_addr = '0, tx_wr_addr = '0;
  logic rx_drop, tx_ser, tx_insert;
  int nchk = 0, nfail = 0;

  always #(PERIOD/2) rx_clk = ~rx_clk;
  always #(PERIOD/2) tx_clk = ~tx_clk;

  pcm_slot_marker uut (.*);

  // fields: e1, tx sync offset, rx table frame 0, rx table later, tx table frame 0, tx table later
  localparam logic [136:0] VEC [4] = '{
    {1'b1, 8'd0, 32'h0000_0001, 32'h8000_0000, 32'h0000_0003, 32'hF0F0_0000},
    {1'b0, 8'd3, 32'h00FF_FFFF, 32'h0080_0001, 32'h00AA_AAAA, 32'h0000_0000},
    {1'b1, 8'd5, 32'hFFFF_FFFF, 32'h5555_5555, 32'h8000_0001, 32'hFFFF_FFFF},
    {1'b0, 8'd0, 32'h0000_0000, 32'h0000_0100, 32'h0080_0000, 32'h00FF_FFFF}
  };

  function automatic logic srcb(int j); return j[0] ^ j[2]; endfunction
  function automatic logic altb(int j); return ~j[1] ^ j[3]; endfunction
  function automatic logic mark(logic e1, logic [31:0] en, int p);
    if (!e1 && p == 0) return 1'b0;
    return e1 ? en[p/8] : en[(p-1)/8];
  endfunction

  task automatic chk(string req, logic act, logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(logic e1);
    rst_n = 1'b0; e1_mode = e1;
    rx_sync = 0; tx_sync = 0; rx_wr_en = 0; tx_wr_en = 0;
    repeat (2) @(posedge rx_clk);
    #2 rst_n = 1'b1;
  endtask

  initial begin
    #(PERIOD * 100000);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    for (int v = 0; v < 4; v++) begin
      logic e1; int off, len;
      logic [31:0] arx, brx, atx, btx;
      logic prev;
      e1 = VEC[v][136]; off = int'(VEC[v][135:128]);
      arx = VEC[v][127:96]; brx = VEC[v][95:64];
      atx = VEC[v][63:32];  btx = VEC[v][31:0];
      len = e1 ? 256 : 193;
      do_reset(e1);
      prev = 1'b0;
      // preamble: load frame-0 tables, nothing synced yet
      for (int k = 0; k <= 32; k++) begin
        @(posedge rx_clk); #2;
        if (k > 0) begin
          chk("R1", rx_drop, 1'b0);
          chk("R1", tx_insert, 1'b0);
          chk("R1", tx_ser, prev);
        end
        if (k < 32) begin
          rx_wr_en = 1; tx_wr_en = 1;
          rx_wr_addr = 5'(k); tx_wr_addr = 5'(k);
          rx_wr_data = arx[k]; tx_wr_data = atx[k];
          tx_src = srcb(k + 5); prev = tx_src;
        end else begin
          rx_wr_en = 0; tx_wr_en = 0;
        end
      end
      // two frames; sample each bit at rising edge + 2 (R10 timing)
      for (int j = 0; j <= 2 * len; j++) begin
        @(posedge rx_clk); #2;
        if (j > 0) begin
          int b, fr, p, tb;
          logic ei;
          b = j - 1; fr = b / len; p = b % len;
          chk(fr > 0 ? "R8" : (!e1 && p == 0) ? "R5" : e1 ? "R3" : "R4",
              rx_drop, mark(e1, fr == 0 ? arx : brx, p));
          if (b < off) begin
            chk("R9", tx_insert, 1'b0);
            chk("R9", tx_ser, srcb(b));
          end else begin
            tb = b - off;
            ei = mark(e1, (tb / len) == 0 ? atx : btx, tb % len);
            chk(tb / len > 0 ? "R11" : "R6", tx_insert, ei);
            chk("R7", tx_ser, ei ? altb(b) : srcb(b));
          end
        end
        if (j < 2 * len) begin
          rx_sync = (j == 0);
          tx_sync = (j == off);
          tx_src = srcb(j); alt_dat = altb(j);
          if (j >= 10 && j < 42) begin
            rx_wr_en = 1; tx_wr_en = 1;
            rx_wr_addr = 5'(j - 10); tx_wr_addr = 5'(j - 10);
            rx_wr_data = brx[j-10]; tx_wr_data = btx[j-10];
          end else begin
            rx_wr_en = 0; tx_wr_en = 0;
          end
        end else begin
          rx_sync = 0; tx_sync = 0;
        end
      end
    end

    // mid-frame resync and edge timing, E1 with only slot 1 dropped
    do_reset(1'b1);
    @(posedge rx_clk); #2;
    rx_wr_en = 1; rx_wr_addr = 5'd1; rx_wr_data = 1;
    @(posedge rx_clk); #2;
    rx_wr_en = 0;
    for (int j = 0; j <= 36; j++) begin
      @(posedge rx_clk); #2;
      if (j > 0) begin
        int b, p;
        b = j - 1; p = (b < 20) ? b : b - 20;
        chk(b >= 20 ? "R2" : "R3", rx_drop, (p / 8) == 1);
      end
      if (j < 36) rx_sync = (j == 0 || j == 20);
      else rx_sync = 0;
      if (j == 28) begin
        #5 chk("R10", rx_drop, 1'b0);
      end
    end
    // asynchronous reset while slot is dropped
    #1 rst_n = 1'b0;
    #1 chk("R1", rx_drop, 1'b0);
    chk("R1", tx_insert, 1'b0);
    @(posedge rx_clk); #2 rst_n = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule